// File: doc/BRIEF.md
# Buffered Serial Word Receiver

This block is the receive half of a synchronous serial port. Three external pins carry the serial bit clock, a frame marker and the data line. All three are oversampled by the core clock. A synchronizer and an edge detector turn the serial clock into a one-cycle sampling strobe. Configuration inputs choose which serial clock edge samples the line and whether a word is assembled most-significant bit first or least-significant bit first.

Each 16-bit word that is complete enters a 32-entry queue. The host takes data from the queue through a 32-bit read port, and every accepted read removes two words. Status outputs give the number of queued words and a data-available flag. A sticky overrun flag records any word that arrived while the queue was full.

Top module: `rxq_serial_receiver`

## Requirements
- R1: While reset is asserted, and after it is released with no serial activity, `level` is 0 and `data_avail` and `overrun` are 0.
- R2: A word starts only at a sampling edge where `rx_frame` is high, and that edge's data bit is the word's first bit. Once the word has 16 bits it is queued. Sampling edges that come while no word is open, and without the frame marker, are ignored.
- R3: A frame marker at a sampling edge in the middle of a word throws away the partial word and starts a new word with that edge's bit.
- R4: With `cfg_lsb_first` = 0 the first received bit becomes bit 15 of the word and the last received bit becomes bit 0.
- R5: With `cfg_lsb_first` = 1 the first received bit becomes bit 0 of the word and the last received bit becomes bit 15.
- R6: With `cfg_fall_edge` = 0, pins are sampled on the 0→1 transition of `rx_sclk`. With `cfg_fall_edge` = 1 they are sampled on the 1→0 transition. The other transition has no effect.
- R7: The queue holds up to 32 words, and `level` gives the exact count from 0 to 32.
- R8: A word that completes while `level` is 32 is discarded, and the queued contents are unchanged. `overrun` then goes to 1 and stays at 1 until `ovr_clr` is pulsed. If a discard and a clear happen in the same cycle, the flag stays set.
- R9: `data_avail` is 1 exactly when `level` ≥ 2. While it is 1, `rd_data[15:0]` holds the oldest queued word and `rd_data[31:16]` holds the next one. A cycle with `rd_en` high removes both words.
- R10: `rd_en` while `level` < 2 is ignored: no word is removed and `level` does not change.
- R11: If a word is queued in the same cycle that a read is accepted, `level` drops by exactly one. The new word goes behind the remaining words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sclk | input | 1 | External serial bit clock |
| rx_frame | input | 1 | External frame marker |
| rx_sdata | input | 1 | External serial data |
| cfg_fall_edge | input | 1 | 0: sample on rising edge, 1: sample on falling edge |
| cfg_lsb_first | input | 1 | 0: MSB first, 1: LSB first |
| rd_en | input | 1 | Host read strobe, removes two words |
| ovr_clr | input | 1 | Clears the overrun flag |
| rd_data | output | 32 | Two oldest words, older word in the low half |
| level | output | 6 | Number of queued words |
| data_avail | output | 1 | At least two words queued |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Between sampling edges, the bench inverts the data line. A design that samples on the wrong serial clock edge therefore assembles the complement of every word. The bench sends a partial framed word followed by a full one, which exposes a design that does not restart on a frame or does not discard the partial bits. It also clocks in unframed bits while no word is open, which catches a design that opens words without a marker. It fills the queue past 32 words and then reads everything back, so a design that overwrites queued data or lets the overrun flag drop early shows wrong contents or a cleared flag. It times a read to the exact cycle in which a word is queued, which catches a level counter that loses one of the two updates.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;

  typedef struct packed {
    logic sclk;
    logic frame;
    logic sdata;
  } pin_sample_t;

endpackage

// File: rtl/rxq_pin_sampler.sv
module rxq_pin_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  rxq_pkg::pin_sample_t pins_i,
  input  rxq_pkg::edge_sel_e  edge_sel_i,
  output logic                strobe_o,
  output logic                frame_o,
  output logic                data_o
);
  import rxq_pkg::*;

  localparam int LAST = SYNC_STAGES - 1;

  pin_sample_t sync_q [SYNC_STAGES];
  logic        prev_sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      prev_sclk_q <= 1'b0;
    end else begin
      sync_q[0] <= pins_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_sclk_q <= sync_q[LAST].sclk;
    end
  end

  always_comb begin
    if (edge_sel_i == EDGE_FALL) strobe_o = !sync_q[LAST].sclk && prev_sclk_q;
    else                         strobe_o = sync_q[LAST].sclk && !prev_sclk_q;
  end

  assign frame_o = sync_q[LAST].frame;
  assign data_o  = sync_q[LAST].sdata;

  // R6
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);

endmodule

// File: rtl/rxq_assembler.sv
module rxq_assembler #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic              frame_i,
  input  logic              data_i,
  input  logic              lsb_first_i,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  logic              open_q, open_d;
  logic [CNT_W-1:0]  bits_q, bits_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              push_q, push_d;
  logic              take;

  assign take = strobe_i && (frame_i || open_q);

  always_comb begin
    open_d = open_q;
    bits_d = bits_q;
    sh_d   = sh_q;
    push_d = 1'b0;
    if (take) begin
      if (lsb_first_i) sh_d = {data_i, sh_q[WORD_W-1:1]};
      else             sh_d = {sh_q[WORD_W-2:0], data_i};
      bits_d = frame_i ? CNT_W'(1) : bits_q + CNT_W'(1);
      open_d = 1'b1;
      if (bits_d == FULL_CNT) begin
        push_d = 1'b1;
        open_d = 1'b0;
        bits_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      bits_q <= '0;
      sh_q   <= '0;
      push_q <= 1'b0;
    end else begin
      push_q <= push_d;
      if (take) begin
        open_q <= open_d;
        bits_q <= bits_d;
        sh_q   <= sh_d;
      end
    end
  end

  assign push_o = push_q;
  assign word_o = sh_q;

  // R2
  push_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |=> !push_q);

  // R3
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && frame_i) |=> (bits_q == CNT_W'(1)) && open_q);

  // R2
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !frame_i && !open_q) |=> !open_q && !push_q);

endmodule

// File: rtl/rxq_queue.sv
module rxq_queue #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic [WORD_W-1:0]          wdata_i,
  input  logic                       pop_req_i,
  input  logic                       ovr_clr_i,
  output logic [2*WORD_W-1:0]        pair_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o,
  output logic                       avail_o,
  output logic                       overrun_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH + 1);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d, rd_nxt;
  logic [LVL_W-1:0]  level_q, level_d;
  logic              ovr_q, ovr_d;
  logic              full, wr_ok, pop_ok;

  assign full   = (level_q == LVL_W'(DEPTH));
  assign wr_ok  = push_i && !full;
  assign pop_ok = pop_req_i && (level_q >= LVL_W'(2));
  assign rd_nxt = ptr_inc(rd_ptr_q);

  always_comb begin
    wr_ptr_d = wr_ok  ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop_ok ? ptr_inc(rd_nxt)   : rd_ptr_q;
    level_d  = level_q + (wr_ok ? LVL_W'(1) : '0) - (pop_ok ? LVL_W'(2) : '0);
    if (push_i && full) ovr_d = 1'b1;
    else if (ovr_clr_i) ovr_d = 1'b0;
    else                ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      ovr_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
      ovr_q    <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr_q] <= wdata_i;
  end

  assign pair_o    = {mem[rd_nxt], mem[rd_ptr_q]};
  assign level_o   = level_q;
  assign avail_o   = (level_q >= LVL_W'(2));
  assign overrun_o = ovr_q;

  // R7
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LVL_W'(DEPTH));

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !ovr_clr_i) |=> ovr_q);

  // R8
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full && !pop_req_i) |=> (level_q == $past(level_q)) && ovr_q);

  // R9
  pop_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req_i && avail_o && !push_i) |=> level_q == $past(level_q) - LVL_W'(2));

  // R10
  pop_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req_i && !avail_o && !push_i) |=> $stable(level_q));

  // R11
  push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req_i && avail_o && push_i && !full) |=> level_q == $past(level_q) - LVL_W'(1));

endmodule

// File: rtl/rxq_serial_receiver.sv
module rxq_serial_receiver #(
  parameter int WORD_W      = 16,
  parameter int DEPTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_sclk,
  input  logic                       rx_frame,
  input  logic                       rx_sdata,
  input  logic                       cfg_fall_edge,
  input  logic                       cfg_lsb_first,
  input  logic                       rd_en,
  input  logic                       ovr_clr,
  output logic [2*WORD_W-1:0]        rd_data,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       data_avail,
  output logic                       overrun
);
  import rxq_pkg::*;

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  pin_sample_t       pins;
  edge_sel_e         edge_sel;
  logic              strobe, s_frame, s_data, push;
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  assign pins     = '{sclk: rx_sclk, frame: rx_frame, sdata: rx_sdata};
  assign edge_sel = cfg_fall_edge ? EDGE_FALL : EDGE_RISE;

  rxq_pin_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .pins_i     (pins),
    .edge_sel_i (edge_sel),
    .strobe_o   (strobe),
    .frame_o    (s_frame),
    .data_o     (s_data)
  );

  rxq_assembler #(.WORD_W(WORD_W)) u_assembler (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .strobe_i    (strobe),
    .frame_i     (s_frame),
    .data_i      (s_data),
    .lsb_first_i (cfg_lsb_first),
    .push_o      (push),
    .word_o      (word)
  );

  rxq_queue #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .push_i    (push),
    .wdata_i   (word),
    .pop_req_i (rd_en),
    .ovr_clr_i (ovr_clr),
    .pair_o    (rd_data),
    .level_o   (level),
    .avail_o   (data_avail),
    .overrun_o (overrun)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(core_rst_n) |-> (level == '0) && !overrun);

endmodule

// File: tb/test_rxq_serial_receiver.sv
module test_rxq_serial_receiver;

  logic        clk = 1'b0;
  logic        rst_n, rx_sclk, rx_frame, rx_sdata;
  logic        cfg_fall_edge, cfg_lsb_first, rd_en, ovr_clr;
  logic [31:0] rd_data;
  logic [5:0]  level;
  logic        data_avail, overrun;

  int checks = 0;
  int errors = 0;
  logic [15:0] mq[$];
  bit exp_ovr = 1'b0;

  always #5 clk = ~clk;

  rxq_serial_receiver i_rxq_serial_receiver (
    .clk(clk), .rst_n(rst_n), .rx_sclk(rx_sclk), .rx_frame(rx_frame),
    .rx_sdata(rx_sdata), .cfg_fall_edge(cfg_fall_edge),
    .cfg_lsb_first(cfg_lsb_first), .rd_en(rd_en), .ovr_clr(ovr_clr),
    .rd_data(rd_data), .level(level), .data_avail(data_avail),
    .overrun(overrun)
  );

  function automatic bit bit_at(input logic [15:0] w, input int i, input bit lsb);
    return lsb ? w[i] : w[15-i];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic status(input string req);
    chk(level == 6'(mq.size()), req, "level", level, mq.size());
    chk(data_avail == (mq.size() >= 2), req, "data_avail", data_avail, mq.size() >= 2);
    chk(overrun == exp_ovr, req, "overrun", overrun, exp_ovr);
  endtask

  task automatic set_mode(input bit fall, input bit lsb);
    @(negedge clk);
    cfg_fall_edge = fall;
    cfg_lsb_first = lsb;
    rx_sclk = fall;
    rx_frame = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic model_push(input logic [15:0] w);
    if (mq.size() >= 32) exp_ovr = 1'b1;
    else mq.push_back(w);
  endtask

  task automatic read_pair(input string req);
    @(negedge clk);
    if (mq.size() >= 2) begin
      chk(rd_data == {mq[1], mq[0]}, req, "rd_data", rd_data, {mq[1], mq[0]});
      void'(mq.pop_front());
      void'(mq.pop_front());
    end
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // One serial bit; data inverted between sampling edge and return edge.
  task automatic send_bit(input bit d, input bit f, input bit pop_here);
    @(negedge clk);
    rx_sdata = d;
    rx_frame = f;
    repeat (3) @(negedge clk);
    rx_sclk = ~cfg_fall_edge;
    if (pop_here) begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(rd_data == {mq[1], mq[0]}, "R11", "rd_data", rd_data, {mq[1], mq[0]});
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
    end else begin
      repeat (3) @(negedge clk);
    end
    rx_sdata = ~d;
    rx_frame = 1'b0;
    repeat (3) @(negedge clk);
    rx_sclk = cfg_fall_edge;
  endtask

  task automatic send_word(input logic [15:0] w, input bit pop_at_end);
    for (int i = 0; i < 16; i++)
      send_bit(bit_at(w, i, cfg_lsb_first), i == 0, pop_at_end && i == 15);
    if (pop_at_end) begin
      if (mq.size() >= 32) exp_ovr = 1'b1;
      void'(mq.pop_front());
      void'(mq.pop_front());
      mq.push_back(w);
    end else begin
      model_push(w);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; rx_sclk = 1'b0; rx_frame = 1'b0; rx_sdata = 1'b0;
    cfg_fall_edge = 1'b0; cfg_lsb_first = 1'b0; rd_en = 1'b0; ovr_clr = 1'b0;
    repeat (4) @(negedge clk);
    status("R1");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    status("R1");

    // R4 MSB first, R10 ignored read, R9 pair order
    set_mode(1'b0, 1'b0);
    send_word(16'hA5C3, 1'b0);
    status("R4");
    read_pair("R10");
    status("R10");
    send_word(16'h1234, 1'b0);
    status("R9");
    read_pair("R4");
    status("R9");

    // R5 LSB first
    set_mode(1'b0, 1'b1);
    send_word(16'h8001, 1'b0);
    send_word(16'h3C5A, 1'b0);
    read_pair("R5");

    // R6 falling edge, both orders
    set_mode(1'b1, 1'b0);
    send_word(16'hF00D, 1'b0);
    send_word(16'h0E71, 1'b0);
    read_pair("R6");
    set_mode(1'b1, 1'b1);
    send_word(16'h6B29, 1'b0);
    send_word(16'hD4C7, 1'b0);
    read_pair("R6");

    // R2 unframed bits while idle are ignored
    set_mode(1'b0, 1'b0);
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0, 1'b0);
    repeat (6) @(negedge clk);
    status("R2");
    send_word(16'h0FF0, 1'b0);
    send_word(16'hC001, 1'b0);
    status("R2");
    read_pair("R2");

    // R3 frame mid-word restarts
    for (int i = 0; i < 7; i++) send_bit(1'b1, i == 0, 1'b0);
    send_word(16'hBEEF, 1'b0);
    status("R3");
    send_word(16'h0102, 1'b0);
    read_pair("R3");

    // R7 / R8 fill and overrun
    for (int i = 0; i < 32; i++) send_word(16'(i * 16'h0457 + 16'h11), 1'b0);
    status("R7");
    send_word(16'hDEAD, 1'b0);
    send_word(16'hBEAD, 1'b0);
    status("R8");
    repeat (5) @(negedge clk);
    status("R8");
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    exp_ovr = 1'b0;
    @(negedge clk);
    status("R8");
    for (int i = 0; i < 16; i++) read_pair("R8");
    status("R7");

    // R11 push and pop in the same cycle
    send_word(16'h1111, 1'b0);
    send_word(16'h2222, 1'b0);
    send_word(16'h3333, 1'b0);
    send_word(16'h4444, 1'b1);
    status("R11");
    read_pair("R11");
    status("R11");

    // Random mix
    for (int it = 0; it < 70; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 2) set_mode(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      if (op < 6) begin
        w = 16'($urandom);
        send_word(w, 1'b0);
        status("R9");
      end else begin
        read_pair("R9");
        status("R10");
      end
    end
    while (mq.size() >= 2) read_pair("R9");
    status("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule